// File: doc/BRIEF.md
# I2C Register-Write Target with Per-Byte CRC-8

This block is an I2C target that takes register writes from a host controller and turns them into single-cycle writes on a register-file port. A frame opens with a START condition, carries the target's address byte (R/W bit low), then a register pointer byte, then one or more data bytes, and closes with a STOP. The pointer advances by one after every data byte that is written, so several data bytes sent before the STOP fill consecutive registers.

When CRC checking is enabled, every data byte must be followed by a CRC-8 byte (polynomial 0x07, initial value 0, bits taken MSB first). The CRC of the first data byte covers the address byte, the pointer byte and that data byte. The CRC of each later data byte covers only that byte, and the remainder starts again from zero. A data byte is held back until its CRC byte matches. A wrong CRC gets no acknowledge, and the target then ignores the bus until the next START. SCL and SDA are sampled synchronously to the system clock. The target pulls SDA low through an open-drain enable output. It does not handle reads, and it never holds SCL low.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset the SDA pull-down enable and the write strobe are both low.
- R2: An address byte whose upper seven bits equal `cfg_addr_i` and whose LSB (R/W) is 0 is acknowledged by pulling SDA low through the ninth SCL pulse. With `cfg_addr_i` = 0x08 this is byte 0x10. The pointer byte and the data bytes that follow are acknowledged in the same way.
- R3: With `crc_en_i` low, each data byte produces exactly one single-cycle `wr_en_o` pulse while SCL is low after its eighth bit. The pulse carries `wr_addr_o` equal to the current pointer and `wr_data_o` equal to the byte.
- R4: Each further data byte before a STOP is written to the previous address plus one, wrapping modulo 256.
- R5: An address byte whose upper seven bits differ from `cfg_addr_i` is not acknowledged. No byte after it is acknowledged and nothing is written until the next START.
- R6: A matching address byte with R/W = 1 (0x11 by default) is not acknowledged, and nothing is written.
- R7: With `crc_en_i` high, a data byte is not written when it is acknowledged. It is written only after the following CRC byte equals the CRC-8 (poly 0x07, init 0, MSB first) over the address byte, the pointer byte and that data byte. The matching CRC byte is acknowledged.
- R8: In a CRC-checked block write, the CRC byte for the second and each later data byte is the CRC-8 over that data byte alone, starting from 0.
- R9: A CRC byte that does not match is not acknowledged. The held data byte is dropped, and later bytes get no acknowledge until the next START.
- R10: The accepted address follows `cfg_addr_i`, and the default address 0x08 is then refused.
- R11: A START in the middle of a frame restarts address reception. After a STOP, bytes clocked in without a new START are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level, synchronous to clk |
| sda_i | input | 1 | Bus data level as seen on the wire, synchronous to clk |
| cfg_addr_i | input | 7 | Target address the block answers to |
| crc_en_i | input | 1 | High to require a CRC byte after each data byte |
| sda_oe_o | output | 1 | High to pull SDA low (open drain) |
| wr_en_o | output | 1 | Single-cycle register write strobe |
| wr_addr_o | output | 8 | Register address of the write |
| wr_data_o | output | 8 | Data of the write |

## Verification
Single-byte and three-byte writes are sent both with and without CRC. These runs separate correct pointer stepping from a pointer that never moves, and separate a CRC kept running across bytes from one restarted for each data byte. Frames with a foreign address, with the read bit set, with a flipped CRC bit and with a changed configured address show whether a refusal reaches the acknowledge slot and also blocks every later byte. A repeated START after the pointer byte, and bytes clocked after a STOP, confirm that the frame state is re-armed only by a START.

// File: rtl/i2c_regwr_pkg.sv
// Package: shared widths and the frame-phase type of the I2C register-write
// target. Assumes 8-bit bus bytes and 7-bit target addresses.
package i2c_regwr_pkg;
    localparam int BYTE_W  = 8;
    localparam int TADDR_W = 7;
    localparam int BITCNT_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_CRC
    } phase_e;
endpackage

// File: rtl/i2c_bus_sense.sv
// Module: i2c_bus_sense
// Detects SCL edges and START/STOP conditions from bus levels that are
// already synchronous to clk. Assumes the bus is idle-high at reset.
module i2c_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    // Keep the previous bus levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Decode edges and conditions from old and new levels.
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c_crc8_serial.sv
// Module: i2c_crc8_serial
// Bit-serial CRC-8 remainder, MSB first, initial value zero.
// Assumes clear_i takes priority over shift_i.
module i2c_crc8_serial #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       shift_i,
    input  logic       bit_i,
    output logic [7:0] rem_o
);
    logic [7:0] rem_q;
    logic       fb;

    // Feedback bit of the division step.
    always_comb fb = rem_q[7] ^ bit_i;

    // Update the remainder by one bit, or restart it from zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            rem_q <= '0;
        end else if (shift_i) begin
            rem_q <= {rem_q[6:0], 1'b0} ^ (fb ? POLY : 8'h00);
        end
    end

    assign rem_o = rem_q;
endmodule

// File: rtl/i2c_regwr_fsm.sv
// Module: i2c_regwr_fsm
// Frame sequencer: receives bytes, decides ACK/NACK, checks CRC bytes and
// issues register writes. Assumes a compliant host that changes SDA only
// while SCL is low, except for START and STOP.
module i2c_regwr_fsm
    import i2c_regwr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               sda_i,
    input  logic [TADDR_W-1:0] cfg_addr_i,
    input  logic               crc_en_i,
    input  logic [BYTE_W-1:0]  crc_rem_i,
    output logic               crc_clear_o,
    output logic               crc_shift_o,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
    localparam logic [BITCNT_W-1:0] ACK_BIT  = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] END_BIT  = BITCNT_W'(BYTE_W + 1);

    phase_e              phase_q, next_q;
    logic [BITCNT_W-1:0] bit_cnt_q;
    logic [BYTE_W-1:0]   shift_q, data_q, ptr_q;
    logic                ack_q, commit_q, oe_q, wr_q;

    logic [BYTE_W-1:0] byte_w;
    logic              busy, byte_done, ack_open, ack_close, crc_ok;

    // Byte assembly and slot decode.
    always_comb begin
        byte_w    = {shift_q[BYTE_W-2:0], sda_i};
        busy      = (phase_q != PH_IDLE);
        byte_done = busy & scl_rise_i & (bit_cnt_q == LAST_BIT);
        ack_open  = busy & scl_fall_i & (bit_cnt_q == ACK_BIT);
        ack_close = busy & scl_fall_i & (bit_cnt_q == END_BIT);
        crc_ok    = (byte_w == crc_rem_i);
    end

    // CRC control: restart per frame and after each accepted CRC byte.
    always_comb begin
        crc_clear_o = start_i | (ack_close & (phase_q == PH_CRC));
        crc_shift_o = busy & scl_rise_i & ~start_i & ~stop_i
                    & (bit_cnt_q < ACK_BIT)
                    & (phase_q inside {PH_ADDR, PH_PTR, PH_DATA});
    end

    // Frame state machine with ACK slot handling and write commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            next_q    <= PH_IDLE;
            bit_cnt_q <= '0;
            shift_q   <= '0;
            data_q    <= '0;
            ptr_q     <= '0;
            ack_q     <= 1'b0;
            commit_q  <= 1'b0;
            oe_q      <= 1'b0;
            wr_q      <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (start_i) begin
                phase_q   <= PH_ADDR;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
                ack_q     <= 1'b0;
                commit_q  <= 1'b0;
            end else if (stop_i) begin
                phase_q   <= PH_IDLE;
                bit_cnt_q <= '0;
                oe_q      <= 1'b0;
                commit_q  <= 1'b0;
            end else if (busy) begin
                if (scl_rise_i) begin
                    if (bit_cnt_q < END_BIT) bit_cnt_q <= bit_cnt_q + 1'b1;
                    if (bit_cnt_q < ACK_BIT) shift_q <= byte_w;
                    if (byte_done) begin
                        case (phase_q)
                            PH_ADDR: begin
                                ack_q    <= (byte_w[BYTE_W-1:1] == cfg_addr_i) & ~byte_w[0];
                                commit_q <= 1'b0;
                                next_q   <= PH_PTR;
                            end
                            PH_PTR: begin
                                ack_q    <= 1'b1;
                                commit_q <= 1'b0;
                                ptr_q    <= byte_w;
                                next_q   <= PH_DATA;
                            end
                            PH_DATA: begin
                                ack_q    <= 1'b1;
                                data_q   <= byte_w;
                                commit_q <= ~crc_en_i;
                                next_q   <= crc_en_i ? PH_CRC : PH_DATA;
                            end
                            PH_CRC: begin
                                ack_q    <= crc_ok;
                                commit_q <= crc_ok;
                                next_q   <= PH_DATA;
                            end
                            default: begin
                                ack_q    <= 1'b0;
                                commit_q <= 1'b0;
                            end
                        endcase
                    end
                end else if (ack_open) begin
                    oe_q <= ack_q;
                    wr_q <= ack_q & commit_q;
                end else if (ack_close) begin
                    oe_q      <= 1'b0;
                    bit_cnt_q <= '0;
                    phase_q   <= ack_q ? next_q : PH_IDLE;
                    if (commit_q) ptr_q <= ptr_q + 1'b1;
                    commit_q  <= 1'b0;
                end
            end
        end
    end

    assign sda_oe_o  = oe_q;
    assign wr_en_o   = wr_q;
    assign wr_addr_o = ptr_q;
    assign wr_data_o = data_q;
endmodule

// File: rtl/i2c_regwr_target.sv
// Module: i2c_regwr_target
// Top level of the I2C register-write target with optional per-byte CRC-8.
// Assumes scl_i/sda_i are already synchronised and sda_i is the wired-AND
// bus level, including this block's own pull-down.
module i2c_regwr_target
    import i2c_regwr_pkg::*;
#(
    parameter logic [7:0] CRC_POLY = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [TADDR_W-1:0] cfg_addr_i,
    input  logic               crc_en_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);
    logic scl_rise, scl_fall, start_det, stop_det;
    logic crc_clear, crc_shift;
    logic [BYTE_W-1:0] crc_rem;

    i2c_bus_sense sense_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_crc8_serial #(.POLY(CRC_POLY)) crc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (crc_clear),
        .shift_i (crc_shift),
        .bit_i   (sda_i),
        .rem_o   (crc_rem)
    );

    i2c_regwr_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_i       (sda_i),
        .cfg_addr_i  (cfg_addr_i),
        .crc_en_i    (crc_en_i),
        .crc_rem_i   (crc_rem),
        .crc_clear_o (crc_clear),
        .crc_shift_o (crc_shift),
        .sda_oe_o    (sda_oe_o),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );
endmodule

// File: rtl/i2c_regwr_target_chk.sv
// Module: i2c_regwr_target_chk
// Port-level checker for i2c_regwr_target. It tracks frames with its own
// START/STOP decode. Assumes a host that moves SDA only while SCL is low.
module i2c_regwr_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_oe_o,
    input logic       wr_en_o,
    input logic [7:0] wr_addr_o
);
    logic scl_q, sda_q, in_frame, have_prev;
    logic [7:0] last_addr;
    logic start_c, stop_c;

    // Independent START/STOP decode.
    always_comb begin
        start_c = scl_i & scl_q & sda_q & ~sda_i;
        stop_c  = scl_i & scl_q & ~sda_q & sda_i;
    end

    // Track frame membership and the last written address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            in_frame  <= 1'b0;
            have_prev <= 1'b0;
            last_addr <= '0;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
            if (start_c) begin
                in_frame  <= 1'b1;
                have_prev <= 1'b0;
            end else if (stop_c) begin
                in_frame  <= 1'b0;
                have_prev <= 1'b0;
            end else if (wr_en_o) begin
                have_prev <= 1'b1;
                last_addr <= wr_addr_o;
            end
        end
    end

    // R1 and R2: the pull-down changes only after SCL was seen low.
    a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_i));

    // R3: a write strobe lasts exactly one cycle.
    a_r3_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R3: writes happen while SCL is low.
    a_r3_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !scl_i);

    // R4: consecutive writes in one frame step the address by one.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && have_prev) |-> (wr_addr_o == last_addr + 8'd1));

    // R11: no write outside an open frame.
    a_r11_write_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> in_frame);
endmodule

bind i2c_regwr_target i2c_regwr_target_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o)
);

// File: tb/i2c_regwr_target_tb_top.sv
// Directed bench for i2c_regwr_target: one task per scenario, each checking
// its own acknowledges and the register writes it expects.
module i2c_regwr_target_tb_top;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic [6:0] cfg_addr = 7'h08;
    logic       crc_en = 1'b0;
    logic       sda_oe, wr_en;
    logic [7:0] wr_addr, wr_data;
    wire        sda_line = host_sda & ~sda_oe;

    int n_checks = 0;
    int n_fail = 0;
    int wr_count = 0;
    logic [7:0] log_addr [64];
    logic [7:0] log_data [64];
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_regwr_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (host_scl),
        .sda_i      (sda_line),
        .cfg_addr_i (cfg_addr),
        .crc_en_i   (crc_en),
        .sda_oe_o   (sda_oe),
        .wr_en_o    (wr_en),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data)
    );

    // Record register writes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            log_addr[wr_count % 64] <= wr_addr;
            log_data[wr_count % 64] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; tick(Q);
            host_scl = 1'b1; tick(Q);
            host_scl = 1'b0; tick(Q);
        end
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(2);
        ack = ~sda_line;
        tick(Q - 2);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
    endtask

    task automatic t_single_plain();
        logic a;
        int base = wr_count;
        crc_en = 1'b0;
        bus_start();
        send_byte(8'h10, a); chk(a, "R2 address ack", a, 1);
        send_byte(8'h20, a); chk(a, "R2 pointer ack", a, 1);
        send_byte(8'hA5, a); chk(a, "R2 data ack", a, 1);
        bus_stop();
        chk(wr_count == base + 1, "R3 write count", wr_count - base, 1);
        chk(log_addr[base] == 8'h20, "R3 write addr", log_addr[base], 8'h20);
        chk(log_data[base] == 8'hA5, "R3 write data", log_data[base], 8'hA5);
    endtask

    task automatic t_block_plain();
        logic a;
        logic [7:0] d [3] = '{8'h11, 8'h22, 8'h33};
        int base = wr_count;
        crc_en = 1'b0;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'hFE, a);
        for (int i = 0; i < 3; i++) begin
            send_byte(d[i], a); chk(a, "R4 block data ack", a, 1);
        end
        bus_stop();
        chk(wr_count == base + 3, "R4 block write count", wr_count - base, 3);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] ea = 8'hFE + 8'(i);
            chk(log_addr[base + i] == ea, "R4 block addr (wraps)", log_addr[base + i], ea);
            chk(log_data[base + i] == d[i], "R4 block data", log_data[base + i], d[i]);
        end
    endtask

    task automatic t_foreign_addr();
        logic a;
        int base = wr_count;
        bus_start();
        send_byte(8'h12, a); chk(!a, "R5 foreign address nack", a, 0);
        send_byte(8'h20, a); chk(!a, "R5 later byte nack", a, 0);
        send_byte(8'h55, a); chk(!a, "R5 data byte nack", a, 0);
        bus_stop();
        chk(wr_count == base, "R5 no write", wr_count - base, 0);
    endtask

    task automatic t_read_req();
        logic a;
        int base = wr_count;
        bus_start();
        send_byte(8'h11, a); chk(!a, "R6 read request nack", a, 0);
        send_byte(8'h20, a);
        bus_stop();
        chk(wr_count == base, "R6 no write", wr_count - base, 0);
    endtask

    task automatic t_crc_single();
        logic a;
        logic [7:0] c;
        int base = wr_count;
        crc_en = 1'b1;
        c = crc_upd(crc_upd(crc_upd(8'h00, 8'h10), 8'h05), 8'h3C);
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'h05, a);
        send_byte(8'h3C, a); chk(a, "R7 data ack before CRC", a, 1);
        chk(wr_count == base, "R7 no write before CRC", wr_count - base, 0);
        send_byte(c, a); chk(a, "R7 good CRC ack", a, 1);
        bus_stop();
        chk(wr_count == base + 1, "R7 write after CRC", wr_count - base, 1);
        chk(log_addr[base] == 8'h05, "R7 write addr", log_addr[base], 8'h05);
        chk(log_data[base] == 8'h3C, "R7 write data", log_data[base], 8'h3C);
    endtask

    task automatic t_crc_block();
        logic a;
        logic [7:0] d [3] = '{8'h01, 8'hFE, 8'h55};
        logic [7:0] c;
        int base = wr_count;
        crc_en = 1'b1;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'h80, a);
        for (int i = 0; i < 3; i++) begin
            c = (i == 0) ? crc_upd(crc_upd(crc_upd(8'h00, 8'h10), 8'h80), d[i])
                         : crc_upd(8'h00, d[i]);
            send_byte(d[i], a);
            send_byte(c, a); chk(a, "R8 per-byte CRC ack", a, 1);
        end
        bus_stop();
        chk(wr_count == base + 3, "R8 block write count", wr_count - base, 3);
        chk(log_addr[base + 2] == 8'h82, "R8 third addr", log_addr[base + 2], 8'h82);
        chk(log_data[base + 1] == 8'hFE, "R8 second data", log_data[base + 1], 8'hFE);
    endtask

    task automatic t_crc_bad();
        logic a;
        logic [7:0] c;
        int base = wr_count;
        crc_en = 1'b1;
        c = crc_upd(crc_upd(crc_upd(8'h00, 8'h10), 8'h10), 8'h77) ^ 8'h01;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'h10, a);
        send_byte(8'h77, a);
        send_byte(c, a); chk(!a, "R9 bad CRC nack", a, 0);
        send_byte(8'h44, a); chk(!a, "R9 later byte nack", a, 0);
        bus_stop();
        chk(wr_count == base, "R9 no write", wr_count - base, 0);
        crc_en = 1'b0;
    endtask

    task automatic t_cfg_addr();
        logic a;
        int base = wr_count;
        cfg_addr = 7'h31;
        bus_start();
        send_byte(8'h10, a); chk(!a, "R10 old address refused", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h62, a); chk(a, "R10 new address ack", a, 1);
        send_byte(8'h09, a);
        send_byte(8'h99, a);
        bus_stop();
        chk(wr_count == base + 1, "R10 write count", wr_count - base, 1);
        chk(log_data[base] == 8'h99, "R10 write data", log_data[base], 8'h99);
        cfg_addr = 7'h08;
    endtask

    task automatic t_restart();
        logic a;
        int base = wr_count;
        crc_en = 1'b0;
        bus_start();
        send_byte(8'h10, a);
        send_byte(8'h30, a);
        bus_start();
        send_byte(8'h10, a); chk(a, "R11 address after repeated START", a, 1);
        send_byte(8'h31, a);
        send_byte(8'hAB, a);
        bus_stop();
        chk(wr_count == base + 1, "R11 write count", wr_count - base, 1);
        chk(log_addr[base] == 8'h31, "R11 write addr", log_addr[base], 8'h31);
        host_scl = 1'b0; tick(Q);
        send_byte(8'h10, a); chk(!a, "R11 byte after STOP ignored", a, 0);
        send_byte(8'h00, a);
        send_byte(8'h77, a);
        chk(wr_count == base + 1, "R11 no write after STOP", wr_count - base, 1);
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_single_plain();
        t_block_plain();
        t_foreign_addr();
        t_read_req();
        t_crc_single();
        t_crc_block();
        t_crc_bad();
        t_cfg_addr();
        t_restart();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule